// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Controller

This block is the interrupt controller of a 16550-style UART. It gathers every interrupt source of the serial port: the sticky break and overrun flags, the parity and framing error levels, the receive character timeout, receive data against the FIFO trigger level, a pending flag for an empty transmit holding register, and the modem status delta bits. It masks each source with its enable bit and picks the most urgent one. From that it builds the interrupt identification byte and drives a single interrupt line.

The surrounding register file sends single-cycle strobes for the accesses that have side effects: an identification read, a holding-register write, an enable-register write and a line-status read. The block also watches the transmit-empty level and a transmit FIFO reset strobe, and from these keeps its own transmit-empty pending latch. The identification byte is combinational from the registered state. The interrupt line is registered, so it follows the identification code one cycle later.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the break and overrun flags are 0, the transmit-empty pending latch is clear, the identification code is 0x1 ("none") and `irq` is 0.
- R2: An enable-register write stores only data bits 3:0. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status, and bit 3 enables modem status. Bits 7:4 of the write data are dropped.
- R3: When several enabled sources are active, the code shows the highest one. The order from highest to lowest is line status, character timeout, receive data, transmit empty pending, modem status.
- R4: The low nibble of `iir` is 0x6 for line status, 0xC for timeout, 0x4 for receive data, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending. Bits 5:4 are 0.
- R5: Receive data counts as a source only with data-ready set. When FIFOs are enabled, `rx_count` must also be greater than or equal to `rx_trig`.
- R6: `iir` bits 7:6 are 11 while `fifo_en` is 1 and 00 otherwise.
- R7: `irq` is a register. It is 1 in the cycle after one in which the code was not 0x1, and 0 otherwise.
- R8: An identification read clears the transmit-empty pending latch only if the code shown during that read is 0x2. A read showing another code leaves the latch as it was.
- R9: A holding-register write clears the transmit-empty pending latch.
- R10: An enable-register write that changes bit 1 sets the latch when the new bit 1 and `thre` are both 1, and clears it otherwise. A write that leaves bit 1 unchanged leaves the latch alone.
- R11: A rising edge of `thre` sets the transmit-empty pending latch.
- R12: A transmit FIFO reset strobe sets the transmit-empty pending latch. This takes precedence over every other event in the same cycle.
- R13: `brk_set` and `ovr_set` set sticky break and overrun flags, which a line-status read clears (a set in the same cycle wins). Parity and framing errors are levels from `err_lvl`. Line status is active while any of the four is 1. `lsr_err` shows {break, framing, parity, overrun}.
- R14: A source whose enable bit is 0 never affects the code. With an enable value of 0 the code is always 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| iir_rd | input | 1 | Identification read strobe |
| thr_wr | input | 1 | Holding-register write strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| txf_reset | input | 1 | Transmit FIFO reset strobe |
| thre | input | 1 | Transmit holding register empty level |
| fifo_en | input | 1 | FIFOs enabled |
| data_ready | input | 1 | Receive data ready level |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level in characters |
| rx_timeout | input | 1 | Character timeout pending |
| brk_set | input | 1 | Break received pulse |
| ovr_set | input | 1 | Overrun pulse |
| err_lvl | input | 2 | {framing, parity} error levels |
| msr_delta | input | 4 | Modem status delta bits |
| ier_q | output | 4 | Stored enable bits |
| lsr_err | output | 4 | {break, framing, parity, overrun} |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or wrongly set transmit-empty latch shows up in the code at once, one cycle after the strobe that should have moved it. This is true whenever transmit-empty is the top enabled source, so the bench isolates it under that mask. A priority or mask error shows in `iir` in the same cycle the sources are applied, and in `irq` one cycle later. For this reason every enable value is swept against every combination of sources. Stuck break or overrun flags appear directly on `lsr_err` and, with line status enabled, as code 0x6 until the next line-status read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM  = 4'h0,
    ID_NONE   = 4'h1,
    ID_THRE   = 4'h2,
    ID_RXDATA = 4'h4,
    ID_LINE   = 4'h6,
    ID_TMO    = 4'hC
  } irq_id_e;

  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // Fixed priority chain over the masked sources.
  function automatic irq_id_e pick_id(input logic [3:0] en, input logic line_act,
                                      input logic tmo_act, input logic rxd_act,
                                      input logic thr_act, input logic msd_act);
    if (en[EN_LINE] && line_act)        return ID_LINE;
    else if (en[EN_RX] && tmo_act)      return ID_TMO;
    else if (en[EN_RX] && rxd_act)      return ID_RXDATA;
    else if (en[EN_THRE] && thr_act)    return ID_THRE;
    else if (en[EN_MODEM] && msd_act)   return ID_MODEM;
    else                                return ID_NONE;
  endfunction

  function automatic logic [1:0] fifo_flag_bits(input logic on);
    return on ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/uart_irq_line_sticky.sv
module uart_irq_line_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_set,
  input  logic ovr_set,
  input  logic lsr_rd,
  output logic brk_q,
  output logic ovr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (brk_set)     brk_q <= 1'b1;
      else if (lsr_rd) brk_q <= 1'b0;
      if (ovr_set)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
    end
  end

  a_r13_read_clears_break: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !brk_set) |=> !brk_q);
  a_r13_overrun_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !lsr_rd) |=> ovr_q);

endmodule

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic thre,
  input  logic txf_reset,
  input  logic thr_wr,
  input  logic thri_chg,
  input  logic thri_new,
  input  logic iir_rd_thr,
  output logic pend_q
);

  logic thre_q;
  logic thre_rise;

  assign thre_rise = thre && !thre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      thre_q <= thre;
      if (txf_reset)       pend_q <= 1'b1;
      else if (thr_wr)     pend_q <= 1'b0;
      else if (thri_chg)   pend_q <= thri_new && thre;
      else if (iir_rd_thr) pend_q <= 1'b0;
      else if (thre_rise)  pend_q <= 1'b1;
    end
  end

  a_r12_fifo_reset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    txf_reset |=> pend_q);
  a_r9_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txf_reset) |=> !pend_q);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_thr && !txf_reset && !thr_wr && !thri_chg) |=> !pend_q);
  a_r10_enable_without_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (thri_chg && !thre && !txf_reset) |=> !pend_q);

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       en,
  input  logic             line_act,
  input  logic             rx_timeout,
  input  logic             data_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             thr_pend,
  input  logic [3:0]       msr_delta,
  output irq_id_e          id,
  output logic             rxd_act
);

  assign rxd_act = data_ready && (!fifo_en || (rx_count >= rx_trig));
  assign id = pick_id(en, line_act, rx_timeout, rxd_act, thr_pend, |msr_delta);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             lsr_rd,
  input  logic             txf_reset,
  input  logic             thre,
  input  logic             fifo_en,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             rx_timeout,
  input  logic             brk_set,
  input  logic             ovr_set,
  input  logic [1:0]       err_lvl,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier_q,
  output logic [3:0]       lsr_err,
  output logic [7:0]       iir,
  output logic             irq
);

  logic    brk_q, ovr_q, thr_pend, rxd_act;
  logic    thri_chg, iir_rd_thr, line_act, unused_hi;
  irq_id_e cur_id;

  assign unused_hi  = ^ier_wdata[7:4];
  assign thri_chg   = ier_wr && (ier_wdata[EN_THRE] != ier_q[EN_THRE]);
  assign iir_rd_thr = iir_rd && (cur_id == ID_THRE);
  assign lsr_err    = {brk_q, err_lvl[1], err_lvl[0], ovr_q};
  assign line_act   = |lsr_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q <= 4'h0;
      irq   <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata[3:0];
      irq <= (cur_id != ID_NONE);
    end
  end

  uart_irq_line_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .brk_set(brk_set), .ovr_set(ovr_set),
    .lsr_rd(lsr_rd), .brk_q(brk_q), .ovr_q(ovr_q)
  );

  uart_irq_thre_latch u_thre (
    .clk(clk), .rst_n(rst_n), .thre(thre), .txf_reset(txf_reset),
    .thr_wr(thr_wr), .thri_chg(thri_chg), .thri_new(ier_wdata[EN_THRE]),
    .iir_rd_thr(iir_rd_thr), .pend_q(thr_pend)
  );

  uart_irq_prio_enc #(.CNT_W(CNT_W)) u_enc (
    .en(ier_q), .line_act(line_act), .rx_timeout(rx_timeout),
    .data_ready(data_ready), .fifo_en(fifo_en), .rx_count(rx_count),
    .rx_trig(rx_trig), .thr_pend(thr_pend), .msr_delta(msr_delta),
    .id(cur_id), .rxd_act(rxd_act)
  );

  assign iir = {fifo_flag_bits(fifo_en), 2'b00, cur_id};

  a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(iir[3:0]) != 4'h1)));
  a_r14_masked_all: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'h0) |-> (iir[3:0] == 4'h1));
  a_r2_high_bits_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == $past(ier_wdata[3:0])));
  a_r5_no_data_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !rx_timeout && ier_q == 4'h1) |-> (iir[3:0] == 4'h1));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;

  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_wr = 0, iir_rd = 0, thr_wr = 0, lsr_rd = 0, txf_reset = 0;
  logic [7:0] ier_wdata = 8'h00;
  logic thre = 0, fifo_en = 0, data_ready = 0, rx_timeout = 0;
  logic brk_set = 0, ovr_set = 0;
  logic [CW-1:0] rx_count = '0, rx_trig = '0;
  logic [1:0] err_lvl = 2'b00;
  logic [3:0] msr_delta = 4'h0;
  logic [3:0] ier_q, lsr_err;
  logic [7:0] iir;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .lsr_rd(lsr_rd), .txf_reset(txf_reset),
    .thre(thre), .fifo_en(fifo_en), .data_ready(data_ready),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .brk_set(brk_set), .ovr_set(ovr_set), .err_lvl(err_lvl),
    .msr_delta(msr_delta), .ier_q(ier_q), .lsr_err(lsr_err), .iir(iir), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model of the selection: first enabled active source wins.
  function automatic logic [3:0] model_id(input logic [3:0] en, input logic ls,
      input logic to, input logic rd, input logic tp, input logic ms);
    logic [3:0] r;
    r = 4'h1;
    if (en[3] && ms) r = 4'h0;
    if (en[1] && tp) r = 4'h2;
    if (en[0] && rd) r = 4'h4;
    if (en[0] && to) r = 4'hC;
    if (en[2] && ls) r = 4'h6;
    return r;
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_wr = 1; tick; ier_wr = 0;
  endtask
  task automatic pulse_thr;  thr_wr = 1; tick; thr_wr = 0; endtask
  task automatic pulse_txf;  txf_reset = 1; tick; txf_reset = 0; endtask
  task automatic pulse_iir;  iir_rd = 1; tick; iir_rd = 0; endtask
  task automatic pulse_lsr;  lsr_rd = 1; tick; lsr_rd = 0; endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick; tick;
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ier", ier_q, 4'h0);
    check("R1 iir", iir, 8'h01);
    check("R1 irq", irq, 0);
    check("R1 lsr", lsr_err, 4'h0);

    // R2 only low nibble kept
    wr_ier(8'hF5);
    check("R2 ier", ier_q, 4'h5);
    wr_ier(8'h00);

    // R3 R4 R14 R7 sweep: all enables x all sources x pending state
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 16; e++) begin
        wr_ier(8'(e));
        if (p == 0) pulse_thr; else pulse_txf;
        for (int s = 0; s < 16; s++) begin
          err_lvl    = {1'b0, s[0]};
          rx_timeout = s[1];
          data_ready = s[2];
          msr_delta  = {3'b000, s[3]};
          tick;
          check("R3 R4 R14 code", iir,
                {4'h0, model_id(4'(e), s[0], s[1], s[2], p[0], s[3])});
          tick;
          check("R7 irq", irq, model_id(4'(e), s[0], s[1], s[2], p[0], s[3]) != 4'h1);
        end
        err_lvl = 0; rx_timeout = 0; data_ready = 0; msr_delta = 0;
      end
    end
    pulse_thr;

    // R5 R6 trigger sweep with FIFOs on
    wr_ier(8'h01);
    fifo_en = 1; data_ready = 1;
    for (int t = 0; t < 4; t++) begin
      rx_trig = (t == 0) ? 5'd1 : (t == 1) ? 5'd4 : (t == 2) ? 5'd8 : 5'd14;
      for (int c = 0; c <= 16; c++) begin
        rx_count = 5'(c);
        tick;
        check("R5 R6 fifo code", iir, (c >= int'(rx_trig)) ? 8'hC4 : 8'hC1);
      end
    end
    data_ready = 0; rx_count = 5'd16; tick;
    check("R5 no ready", iir, 8'hC1);
    fifo_en = 0; rx_count = 0; tick;
    check("R6 fifo off", iir[7:6], 2'b00);

    // R8 read clears only when showing 0x2
    wr_ier(8'h02); pulse_txf;
    check("R8 shown", iir, 8'h02);
    pulse_iir;
    check("R8 cleared", iir, 8'h01);
    wr_ier(8'h06); pulse_txf; err_lvl = 2'b01; tick;
    check("R8 line shown", iir, 8'h06);
    pulse_iir;
    err_lvl = 2'b00; tick;
    check("R8 kept", iir, 8'h02);

    // R9 holding write clears
    pulse_thr;
    check("R9 cleared", iir, 8'h01);

    // R10 enable write edges
    wr_ier(8'h00); thre = 1; tick;
    wr_ier(8'h02);
    check("R10 arm", iir, 8'h02);
    pulse_iir;
    wr_ier(8'h03);
    check("R10 unchanged bit", iir, 8'h01);
    wr_ier(8'h01); thre = 0; tick;
    wr_ier(8'h02);
    check("R10 not empty", iir, 8'h01);

    // R11 rising thre
    thre = 1; tick;
    check("R11 rise", iir, 8'h02);
    pulse_thr;

    // R12 fifo reset wins over holding write
    thr_wr = 1; txf_reset = 1; tick; thr_wr = 0; txf_reset = 0;
    check("R12 wins", iir, 8'h02);
    pulse_thr;

    // R13 sticky flags
    wr_ier(8'h04);
    brk_set = 1; tick; brk_set = 0; tick;
    check("R13 break", lsr_err, 4'h8);
    check("R13 code", iir, 8'h06);
    pulse_lsr;
    check("R13 break cleared", lsr_err, 4'h0);
    check("R13 code none", iir, 8'h01);
    ovr_set = 1; tick; ovr_set = 0;
    check("R13 overrun", lsr_err, 4'h1);
    ovr_set = 1; lsr_rd = 1; tick; ovr_set = 0; lsr_rd = 0;
    check("R13 set wins", lsr_err, 4'h1);
    pulse_lsr;
    check("R13 overrun cleared", lsr_err, 4'h0);
    err_lvl = 2'b10; tick;
    check("R13 framing level", lsr_err, 4'h4);
    err_lvl = 2'b00; tick;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule